// File: doc/BRIEF.md
# Compare-Match Event Timer with Divided System Count

This block keeps a free-running 64-bit count that advances once for every three cycles of its input clock, and pairs it with a single compare unit. Software reaches it through a single-cycle 32-bit register port. Read data is combinational from the address, and a write takes effect on the clock edge that closes the access. The count is read as two separate 32-bit halves. Software resolves a carry between the two reads by reading the high half, then the low half, then the high half again, and retrying if the two high values differ.

To schedule an event, software turns the compare unit off, reads the count, and writes a target value in two halves. Only 52 bits of the target are stored. Software then sets the enable bit. Once the count is equal to or beyond the target while the unit is enabled, a sticky status flag rises and the interrupt output follows it unless the mask bit is set. Writing the enable bit back to zero is the only way to acknowledge the event. That write clears the status flag and the interrupt together.

Top module: `sys_cmp_timer`

## Requirements
- R1: After reset is released, the count equals floor(N/3), where N is the number of rising clock edges seen with reset high. The count runs continuously and does not depend on the enable bit.
- R2: A read at address 0x00008 returns count bits 31:0. A read at 0x0000C returns count bits 63:32.
- R3: The compare low word at 0x10020 stores all 32 written bits and reads them back. The compare high word at 0x10024 stores only written bits 19:0 and reads those back zero-extended. Written bits 31:20 are ignored.
- R4: The control register is at 0x1002C. Bit 0 is enable, bit 1 is interrupt mask, and bit 2 is the read-only status flag. Writes to bit 2 and to bits 31:3 have no effect, and those upper bits read as 0.
- R5: The status flag sets on the first clock edge at which enable was already 1 and the registered count was greater than or equal to the 52-bit compare value {high[19:0], low}. It then stays set for as long as enable stays 1. While enable is 0 it is never set, and a target with a nonzero high word is never reached during a short run.
- R6: The interrupt output is a register holding status AND enable AND NOT mask. It rises on the same edge as the status flag. A write that sets the mask drops it on that write's edge and leaves status set. Clearing the mask raises it again on that edge.
- R7: A control write with bit 0 equal to 0 clears status and the interrupt on the write's edge. This holds even if a match would set status on that same edge.
- R8: If enable is written to 1 while the count is already at or past the target, status and the interrupt stay low on the write's edge and rise on the following edge.
- R9: Reset clears the count, the prescaler phase, both compare words and the control register, and holds the interrupt low.
- R10: A read of any other address returns 0. A write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 17 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Registered compare interrupt |

## Verification
A compare match and a disabling control write can fall in the same cycle. The bench provokes this by arming a target and then timing the write of enable 0 from its own edge counter. The write is placed on the exact edge at which the newly reached count would first set the status flag. The case passes only if the interrupt never rises and the control register reads back all zeros afterwards. A second overlap, a mask write while status is already set, is judged by the interrupt dropping on that write's edge while the status bit still reads back as 1.

// File: rtl/tct_pkg.sv
package tct_pkg;
   // control register bit positions (software visible)
   localparam int unsigned CTL_EN_BIT   = 0;
   localparam int unsigned CTL_MASK_BIT = 1;
   localparam int unsigned CTL_STAT_BIT = 2;

   typedef struct packed {
      logic mask;
      logic en;
   } tct_ctrl_t;

   localparam tct_ctrl_t CTRL_RESET = '{mask: 1'b0, en: 1'b0};
endpackage

// File: rtl/tct_prescaler.sv
module tct_prescaler #(
   parameter int unsigned DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad
         $error("tct_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_pass
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int unsigned PH_W = $clog2(DIV);
         localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);
         logic [PH_W-1:0] phase_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (phase_q == LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end

         assign tick_o = (phase_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   output logic [W-1:0] cnt_o
);
   generate
      if (W < 2) begin : g_bad
         $error("tct_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/tct_compare.sv
module tct_compare #(
   parameter int unsigned CNT_W = 64,
   parameter int unsigned CMP_W = 52
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CMP_W-1:0] cmp_i,
   input  logic             en_q_i,
   input  logic             en_d_i,
   input  logic             mask_d_i,
   output logic             status_o,
   output logic             irq_o
);
   generate
      if (CMP_W > CNT_W) begin : g_bad
         $error("tct_compare: CMP_W may not exceed CNT_W");
      end
   endgenerate

   logic reached;
   logic status_q, status_d;
   logic irq_q, irq_d;

   assign reached = (cnt_i >= CNT_W'(cmp_i));

   always_comb begin
      // a disabling write wins over a match landing on the same edge
      if (en_d_i) begin
         status_d = status_q | (en_q_i & reached);
      end else begin
         status_d = 1'b0;
      end
      irq_d = status_d & en_d_i & ~mask_d_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= status_d;
         irq_q    <= irq_d;
      end
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;
endmodule

// File: rtl/sys_cmp_timer.sv
module sys_cmp_timer #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned CMP_HI_W     = 20,
   parameter int unsigned PRESCALE     = 3,
   parameter int unsigned ADDR_W       = 17,
   parameter logic [16:0] CNT_LO_OFS   = 17'h0_0008,
   parameter logic [16:0] CNT_HI_OFS   = 17'h0_000C,
   parameter logic [16:0] CMP_BASE     = 17'h1_0000,
   parameter logic [16:0] CMP_LO_REL   = 17'h0_0020,
   parameter logic [16:0] CMP_HI_REL   = 17'h0_0024,
   parameter logic [16:0] CMP_CTL_REL  = 17'h0_002C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);
   import tct_pkg::*;

   localparam int unsigned CMP_W = DATA_W + CMP_HI_W;
   localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(CNT_LO_OFS);
   localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(CNT_HI_OFS);
   localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(CMP_BASE + CMP_LO_REL);
   localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(CMP_BASE + CMP_HI_REL);
   localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(CMP_BASE + CMP_CTL_REL);

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
         $error("sys_cmp_timer: CNT_W must be twice DATA_W");
      end
      if (CMP_HI_W < 1 || CMP_HI_W > DATA_W) begin : g_bad_hi
         $error("sys_cmp_timer: CMP_HI_W must lie in 1..DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_dw
         $error("sys_cmp_timer: DATA_W too narrow for the control register");
      end
   endgenerate

   // ---------------- count path ----------------
   logic             tick;
   logic [CNT_W-1:0] cnt_val;

   tct_prescaler #(.DIV(PRESCALE)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   tct_counter #(.W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .cnt_o  (cnt_val)
   );

   // ---------------- register decode ----------------
   logic do_wr;
   logic wr_cmp_lo, wr_cmp_hi, wr_ctl;

   assign do_wr     = bus_sel & bus_wr;
   assign wr_cmp_lo = do_wr & (bus_addr == A_CMP_LO);
   assign wr_cmp_hi = do_wr & (bus_addr == A_CMP_HI);
   assign wr_ctl    = do_wr & (bus_addr == A_CTL);

   logic [DATA_W-1:0]   cmp_lo_q;
   logic [CMP_HI_W-1:0] cmp_hi_q;
   tct_ctrl_t           ctrl_q, ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr_ctl) begin
         ctrl_d.en   = bus_wdata[CTL_EN_BIT];
         ctrl_d.mask = bus_wdata[CTL_MASK_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_lo_q <= '0;
         cmp_hi_q <= '0;
         ctrl_q   <= CTRL_RESET;
      end else begin
         if (wr_cmp_lo) cmp_lo_q <= bus_wdata;
         if (wr_cmp_hi) cmp_hi_q <= bus_wdata[CMP_HI_W-1:0];
         ctrl_q <= ctrl_d;
      end
   end

   // ---------------- compare ----------------
   logic status;

   tct_compare #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_i    (cnt_val),
      .cmp_i    ({cmp_hi_q, cmp_lo_q}),
      .en_q_i   (ctrl_q.en),
      .en_d_i   (ctrl_d.en),
      .mask_d_i (ctrl_d.mask),
      .status_o (status),
      .irq_o    (irq_o)
   );

   logic ctrl_en_q, ctrl_mask_q;
   assign ctrl_en_q   = ctrl_q.en;
   assign ctrl_mask_q = ctrl_q.mask;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         unique case (bus_addr)
            A_CNT_LO: bus_rdata = cnt_val[DATA_W-1:0];
            A_CNT_HI: bus_rdata = cnt_val[CNT_W-1:DATA_W];
            A_CMP_LO: bus_rdata = cmp_lo_q;
            A_CMP_HI: bus_rdata = DATA_W'(cmp_hi_q);
            A_CTL: begin
               bus_rdata[CTL_EN_BIT]   = ctrl_q.en;
               bus_rdata[CTL_MASK_BIT] = ctrl_q.mask;
               bus_rdata[CTL_STAT_BIT] = status;
            end
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/tct_checker.sv
module tct_checker #(
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned PRESCALE = 3,
   parameter logic [ADDR_W-1:0] CTL_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wdata_b0,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              en_q,
   input logic              mask_q,
   input logic              status_q,
   input logic              irq_o
);
   logic ack_wr;
   assign ack_wr = bus_sel && bus_wr && (bus_addr == CTL_ADDR) && !wdata_b0;

   // R1: the count moves by exactly one on a prescaler tick, otherwise holds
   p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == $past(cnt_q) + 1'b1);
   p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

   generate
      if (PRESCALE > 1) begin : g_gap
         p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

   // R5: status never stands while disabled and is sticky while enabled
   p_stat_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !status_q);
   p_stat_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q && !ack_wr) |=> status_q);

   // R6: a masked block never drives the interrupt
   p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_q |-> !irq_o);

   // R7: an acknowledge write clears status and interrupt on its edge
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr |=> (!status_q && !irq_o));
endmodule

bind sys_cmp_timer tct_checker #(
   .CNT_W    (CNT_W),
   .ADDR_W   (ADDR_W),
   .PRESCALE (PRESCALE),
   .CTL_ADDR (A_CTL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wdata_b0 (bus_wdata[0]),
   .tick     (tick),
   .cnt_q    (cnt_val),
   .en_q     (ctrl_en_q),
   .mask_q   (ctrl_mask_q),
   .status_q (status),
   .irq_o    (irq_o)
);

// File: tb/sys_cmp_timer_tb.sv
`timescale 1ns/1ps
module sys_cmp_timer_tb;
   localparam logic [16:0] A_CNT_LO = 17'h0_0008;
   localparam logic [16:0] A_CNT_HI = 17'h0_000C;
   localparam logic [16:0] A_CMP_LO = 17'h1_0020;
   localparam logic [16:0] A_CMP_HI = 17'h1_0024;
   localparam logic [16:0] A_CTL    = 17'h1_002C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [16:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   always #4 clk = ~clk; // 125 MHz

   sys_cmp_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   int edges = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always @(posedge clk) if (rst_n) edges <= edges + 1;

   // scoreboard queues: expected value, kind (0 fixed, 1 count low, 2 count high), tag
   logic [31:0] exp_q[$];
   int          kind_q[$];
   string       tag_q[$];

   task automatic note(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops one expectation per read access at the falling edge
   always @(negedge clk) begin
      if (bus_sel && !bus_wr && exp_q.size() > 0) begin
         logic [31:0] e;
         int          k;
         string       t;
         e = exp_q.pop_front();
         k = kind_q.pop_front();
         t = tag_q.pop_front();
         if (k == 1) e = 32'(edges / 3);
         else if (k == 2) e = 32'((longint'(edges / 3)) >> 32);
         note(t, bus_rdata, e);
      end
   end

   // all tasks start and end 1 ns after a rising edge
   task automatic bus_write(input logic [16:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [16:0] a, input logic [31:0] e,
                           input int kind, input string tag);
      exp_q.push_back(e); kind_q.push_back(kind); tag_q.push_back(tag);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic irq_at_neg(input logic e, input string tag);
      @(negedge clk);
      note(tag, {31'b0, irq_o}, {31'b0, e});
      @(posedge clk); #1;
   endtask

   task automatic sync_to(input int n);
      while (edges < n) begin @(posedge clk); #1; end
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int c;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;

      // R9: reset state
      bus_read(A_CTL,    32'h0, 0, "R9 ctrl after reset");
      bus_read(A_CMP_LO, 32'h0, 0, "R9 cmp lo after reset");
      bus_read(A_CMP_HI, 32'h0, 0, "R9 cmp hi after reset");
      irq_at_neg(1'b0, "R9 irq low after reset");

      // R1/R2: count tracks edges/3
      bus_read(A_CNT_LO, 32'h0, 1, "R1 count low");
      idle(7);
      bus_read(A_CNT_LO, 32'h0, 1, "R1 count low later");
      bus_read(A_CNT_LO, 32'h0, 1, "R1 count low next cycle");
      bus_read(A_CNT_HI, 32'h0, 2, "R2 count high");
      idle(20);
      bus_read(A_CNT_LO, 32'h0, 1, "R2 count low after run");

      // R3: compare registers, upper high bits ignored
      bus_write(A_CMP_HI, 32'hFFFF_FFFF);
      bus_read(A_CMP_HI, 32'h000F_FFFF, 0, "R3 cmp hi keeps 20 bits");
      bus_write(A_CMP_HI, 32'h0);
      bus_write(A_CMP_LO, 32'hA5C3_0F1E);
      bus_read(A_CMP_LO, 32'hA5C3_0F1E, 0, "R3 cmp lo readback");

      // R4: status bit and upper bits not writable
      bus_write(A_CTL, 32'hFFFF_FFFC);
      bus_read(A_CTL, 32'h0, 0, "R4 ctrl ignores bits 31:2");
      bus_write(A_CTL, 32'h2);
      bus_read(A_CTL, 32'h2, 0, "R4 mask bit readback");
      bus_write(A_CTL, 32'h0);

      // R10: unmapped access
      bus_write(17'h1_0028, 32'hFFFF_FFFF);
      bus_write(17'h0_0010, 32'hFFFF_FFFF);
      bus_write(17'h0_0020, 32'h0000_0001);
      bus_read(A_CTL, 32'h0, 0, "R10 ctrl untouched");
      bus_read(A_CMP_LO, 32'hA5C3_0F1E, 0, "R10 cmp lo untouched");
      bus_read(17'h1_0028, 32'h0, 0, "R10 unmapped read");
      bus_read(17'h0_0004, 32'h0, 0, "R10 unmapped low read");

      // R5/R6: match while enabled
      c = edges / 3 + 10;
      bus_write(A_CMP_LO, 32'(c));
      bus_write(A_CTL, 32'h1);
      sync_to(3 * c);
      irq_at_neg(1'b0, "R5 no irq on edge count reaches target");
      irq_at_neg(1'b1, "R6 irq one edge after target reached");
      bus_read(A_CTL, 32'h5, 0, "R5 status set");
      idle(9);
      bus_read(A_CTL, 32'h5, 0, "R5 status sticky");

      // R6: mask and unmask
      bus_write(A_CTL, 32'h3);
      @(negedge clk); note("R6 mask drops irq", {31'b0, irq_o}, 32'h0);
      @(posedge clk); #1;
      bus_read(A_CTL, 32'h7, 0, "R6 status kept while masked");
      bus_write(A_CTL, 32'h1);
      irq_at_neg(1'b1, "R6 unmask restores irq");

      // R7: acknowledge
      bus_write(A_CTL, 32'h0);
      @(negedge clk); note("R7 ack drops irq", {31'b0, irq_o}, 32'h0);
      @(posedge clk); #1;
      bus_read(A_CTL, 32'h0, 0, "R7 ack clears status");

      // R7: disable write on the exact match edge
      c = edges / 3 + 8;
      bus_write(A_CMP_LO, 32'(c));
      bus_write(A_CTL, 32'h1);
      sync_to(3 * c);
      bus_write(A_CTL, 32'h0);
      irq_at_neg(1'b0, "R7 collision irq stays low");
      bus_read(A_CTL, 32'h0, 0, "R7 collision status clear");
      irq_at_neg(1'b0, "R7 collision irq still low");

      // R8: enable when target already passed
      bus_write(A_CMP_LO, 32'h5);
      bus_write(A_CTL, 32'h1);
      @(negedge clk); note("R8 no irq on enable edge", {31'b0, irq_o}, 32'h0);
      @(posedge clk); #1;
      irq_at_neg(1'b1, "R8 irq one edge after enable");
      bus_read(A_CTL, 32'h5, 0, "R8 status set");
      bus_write(A_CTL, 32'h0);

      // R5: nonzero compare high is out of reach
      bus_write(A_CMP_HI, 32'h1);
      bus_write(A_CMP_LO, 32'h0);
      bus_write(A_CTL, 32'h1);
      idle(30);
      bus_read(A_CTL, 32'h1, 0, "R5 52-bit target not reached");
      irq_at_neg(1'b0, "R5 no irq with high target");
      bus_write(A_CTL, 32'h0);
      bus_write(A_CMP_HI, 32'h0);

      // R5: disabled unit never flags
      idle(12);
      bus_read(A_CTL, 32'h0, 0, "R5 disabled no status");
      irq_at_neg(1'b0, "R5 disabled no irq");
      bus_read(A_CNT_LO, 32'h0, 1, "R1 count keeps running");

      idle(3);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule